// File: doc/BRIEF.md
# Prioritised Bus Arbiter with Interrupt Entry Sequencer

This block decides which master owns a shared bus: the processor by default, or one of several peripheral devices. Devices request the bus on two kinds of lines. Direct-transfer lines move data without the processor. Interrupt lines sit on four priority levels, numbered 4 to 7. The arbiter issues one grant at a time. It watches the shared bus-busy line to see the granted device take the bus and later release it. While the bus is not with the processor, it holds the processor stalled.

An interrupt request is granted only when its level is strictly above the processor's current 3-bit priority. Direct-transfer requests ignore that priority and always win over interrupt requests. A device granted through an interrupt line hands over its vector while it owns the bus. The block then issues four interrupt-entry steps, one per free bus cycle, with their memory addresses:
- push the status word;
- push the program counter;
- load the new program counter;
- load the new status word.

While these steps are pending, only direct-transfer requests are granted. The stack pointer and memory are outside the block.

Top module: `prio_bus_arb`

## Requirements
- R1: After reset, every grant output is 0, `cpu_stall` is 0 and `step_valid` is 0.
- R2: A direct-transfer request is granted whatever `cpu_pri` holds. When direct-transfer and interrupt requests are both present at a decision, the direct-transfer request is granted.
- R3: An interrupt request on level L is granted only if L > `cpu_pri`. Interrupt bit `(L-4)*NDEV + d` is device d on level L.
- R4: Among interrupt requests, the highest level wins, and within a level the lowest device index wins. Among direct-transfer requests, the lowest index wins.
- R5: At most one grant is outstanding. No grant is issued while `bbsy_in` is 1. A grant stays asserted until `bbsy_in` is seen at 1, and it is cleared on the next clock.
- R6: After a direct-transfer owner drops `bbsy_in`, control returns to the processor and `cpu_stall` falls.
- R7: While an interrupt owner holds the bus, `vec_valid` captures `vec_in` and `sp_in`. Four steps then follow in order:
  - kind 0 (push status) at sp-2;
  - kind 1 (push PC) at sp-4;
  - kind 2 (load PC) at vec;
  - kind 3 (load status) at vec+2.
- R8: While entry steps are pending, interrupt requests are not granted. Direct-transfer requests still are.
- R9: An entry step is issued only in a cycle when the bus is free: `bbsy_in` is 0, no grant or ownership is in progress, and no direct-transfer request is waiting.
- R10: `cpu_stall` is 1 from the cycle a grant appears until the last entry step is issued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| npr_req | input | NPR_N | Direct-transfer requests, index 0 nearest |
| npr_gnt | output | NPR_N | Direct-transfer grants |
| irq_req | input | NLVL*NDEV | Interrupt requests by level and device |
| irq_gnt | output | NLVL*NDEV | Interrupt grants |
| cpu_pri | input | PRI_W | Current processor priority |
| bbsy_in | input | 1 | Bus busy, driven by the owning device |
| vec_valid | input | 1 | Vector present from interrupt owner |
| vec_in | input | AW | Interrupt vector address |
| sp_in | input | AW | Current stack pointer |
| cpu_stall | output | 1 | Processor must not use the bus |
| step_valid | output | 1 | An entry step is issued this cycle |
| step_kind | output | 2 | 0 push status, 1 push PC, 2 load PC, 3 load status |
| step_addr | output | AW | Memory address of the step |

## Verification
Two functions can meet in one cycle: issuing interrupt-entry steps and granting a direct transfer. The bench triggers this by raising a direct-transfer request and a top-level interrupt request together, on the first free cycle after the vector handoff. It then checks the following:
- the direct transfer gets the grant and no step is issued in that cycle;
- the interrupt stays ungranted;
- after the transfer owner releases the bus, the four steps resume with unchanged kinds and addresses;
- the waiting interrupt is granted only after the last step.

// File: rtl/arb_pkg.sv
package arb_pkg;
   typedef enum logic [2:0] {
      A_FREE   = 3'd0,
      A_GNPR   = 3'd1,
      A_GIRQ   = 3'd2,
      A_OWN    = 3'd3,
      A_OWNIRQ = 3'd4
   } arb_st_t;

   typedef enum logic [1:0] {
      STEP_PUSH_PS = 2'd0,
      STEP_PUSH_PC = 2'd1,
      STEP_LOAD_PC = 2'd2,
      STEP_LOAD_PS = 2'd3
   } step_t;
endpackage

// File: rtl/arb_pick.sv
module arb_pick #(
   parameter int NPR_N    = 2,
   parameter int NLVL     = 4,
   parameter int NDEV     = 2,
   parameter int PRI_W    = 3,
   parameter int LVL_BASE = 4
) (
   input  logic [NPR_N-1:0]     npr_req,
   input  logic [NLVL*NDEV-1:0] irq_req,
   input  logic [PRI_W-1:0]     cpu_pri,
   output logic                 npr_any,
   output logic [NPR_N-1:0]     npr_sel,
   output logic                 irq_ok,
   output logic [NLVL*NDEV-1:0] irq_sel
);
   localparam int NIRQ = NLVL * NDEV;

   if (LVL_BASE + NLVL > (1 << PRI_W)) begin : g_bad_lvl
      $error("arb_pick: levels exceed priority range");
   end
   if (NDEV < 1 || NPR_N < 1) begin : g_bad_cnt
      $error("arb_pick: device counts must be positive");
   end

   logic             hit;
   logic [PRI_W-1:0] win_lvl;

   always_comb begin
      npr_sel = '0;
      npr_any = 1'b0;
      for (int i = 0; i < NPR_N; i++) begin
         if (npr_req[i] && !npr_any) begin
            npr_sel[i] = 1'b1;
            npr_any    = 1'b1;
         end
      end
   end

   always_comb begin
      irq_sel = '0;
      hit     = 1'b0;
      win_lvl = '0;
      for (int l = NLVL - 1; l >= 0; l--) begin
         for (int d = 0; d < NDEV; d++) begin
            if (irq_req[l*NDEV+d] && !hit) begin
               hit                = 1'b1;
               irq_sel[l*NDEV+d]  = 1'b1;
               win_lvl            = PRI_W'(LVL_BASE + l);
            end
         end
      end
      irq_ok = hit && (win_lvl > cpu_pri);
   end

   logic unused_w;
   assign unused_w = ^NIRQ;
endmodule

// File: rtl/arb_fsm.sv
module arb_fsm
   import arb_pkg::*;
#(
   parameter int NPR_N = 2,
   parameter int NIRQ  = 8,
   parameter int PRI_W = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bbsy_in,
   input  logic              vec_valid,
   input  logic              npr_any,
   input  logic [NPR_N-1:0]  npr_sel,
   input  logic              irq_ok,
   input  logic [NIRQ-1:0]   irq_sel,
   input  logic              seq_busy,
   input  logic [NPR_N-1:0]  npr_req,
   input  logic [PRI_W-1:0]  cpu_pri,
   output logic [NPR_N-1:0]  npr_gnt,
   output logic [NIRQ-1:0]   irq_gnt,
   output logic              seq_start,
   output arb_st_t           st
);
   assign seq_start = (st == A_OWNIRQ) && vec_valid;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st      <= A_FREE;
         npr_gnt <= '0;
         irq_gnt <= '0;
      end else begin
         unique case (st)
            A_FREE: if (!bbsy_in) begin
               if (npr_any) begin
                  npr_gnt <= npr_sel;
                  st      <= A_GNPR;
               end else if (irq_ok && !seq_busy) begin
                  irq_gnt <= irq_sel;
                  st      <= A_GIRQ;
               end
            end
            A_GNPR: if (bbsy_in) begin
               npr_gnt <= '0;
               st      <= A_OWN;
            end
            A_GIRQ: if (bbsy_in) begin
               irq_gnt <= '0;
               st      <= A_OWNIRQ;
            end
            A_OWNIRQ: if (vec_valid) st <= A_OWN;
            A_OWN:    if (!bbsy_in) st <= A_FREE;
            default:  st <= A_FREE;
         endcase
      end
   end

   // R5: grants are one-hot at most and never rise while the bus is busy
   assert_one_grant_R5: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({npr_gnt, irq_gnt}));
   assert_no_gnt_busy_R5: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(|{npr_gnt, irq_gnt}) |-> $past(!bbsy_in));
   // R2: an interrupt grant never overtakes a waiting direct transfer
   assert_npr_first_R2: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(|irq_gnt) |-> ($past(npr_req) == '0));
   // R3: interrupt grant needs the requesting level above the priority
   assert_irq_mask_R3: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(|irq_gnt) |-> ($past(cpu_pri) != '1));
endmodule

// File: rtl/entry_seq.sv
module entry_seq
   import arb_pkg::*;
#(
   parameter int AW = 16
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          start,
   input  logic [AW-1:0] vec_in,
   input  logic [AW-1:0] sp_in,
   input  logic          bus_idle,
   input  logic          bbsy_in,
   output logic          active,
   output logic          step_valid,
   output logic [1:0]    step_kind,
   output logic [AW-1:0] step_addr
);
   localparam logic [AW-1:0] WORD = AW'(2);

   if (AW < 4) begin : g_bad_aw
      $error("entry_seq: address width too small");
   end

   logic [1:0]    cnt;
   logic [AW-1:0] vec_q;
   logic [AW-1:0] sp_q;
   logic [AW-1:0] next_addr;

   always_comb begin
      unique case (step_t'(cnt))
         STEP_PUSH_PS: next_addr = sp_q - WORD;
         STEP_PUSH_PC: next_addr = sp_q - WORD - WORD;
         STEP_LOAD_PC: next_addr = vec_q;
         default:      next_addr = vec_q + WORD;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         active     <= 1'b0;
         cnt        <= '0;
         vec_q      <= '0;
         sp_q       <= '0;
         step_valid <= 1'b0;
         step_kind  <= '0;
         step_addr  <= '0;
      end else if (start) begin
         active     <= 1'b1;
         cnt        <= '0;
         vec_q      <= vec_in;
         sp_q       <= sp_in;
         step_valid <= 1'b0;
      end else if (active && bus_idle) begin
         step_valid <= 1'b1;
         step_kind  <= cnt;
         step_addr  <= next_addr;
         cnt        <= cnt + 2'd1;
         if (cnt == 2'd3) active <= 1'b0;
      end else begin
         step_valid <= 1'b0;
      end
   end

   // R9: a step only follows a cycle with the bus released
   assert_step_free_R9: assert property (@(posedge clk) disable iff (!rst_n)
      step_valid |-> $past(!bbsy_in));
   // R7: back-to-back steps advance by exactly one kind
   assert_step_order_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (step_valid && $past(step_valid)) |-> (step_kind == $past(step_kind) + 2'd1));
endmodule

// File: rtl/prio_bus_arb.sv
module prio_bus_arb
   import arb_pkg::*;
#(
   parameter int NPR_N    = 2,
   parameter int NLVL     = 4,
   parameter int NDEV     = 2,
   parameter int PRI_W    = 3,
   parameter int LVL_BASE = 4,
   parameter int AW       = 16
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [NPR_N-1:0]     npr_req,
   output logic [NPR_N-1:0]     npr_gnt,
   input  logic [NLVL*NDEV-1:0] irq_req,
   output logic [NLVL*NDEV-1:0] irq_gnt,
   input  logic [PRI_W-1:0]     cpu_pri,
   input  logic                 bbsy_in,
   input  logic                 vec_valid,
   input  logic [AW-1:0]        vec_in,
   input  logic [AW-1:0]        sp_in,
   output logic                 cpu_stall,
   output logic                 step_valid,
   output logic [1:0]           step_kind,
   output logic [AW-1:0]        step_addr
);
   localparam int NIRQ = NLVL * NDEV;

   logic             npr_any, irq_ok, seq_start, seq_active, bus_idle;
   logic [NPR_N-1:0] npr_sel;
   logic [NIRQ-1:0]  irq_sel;
   arb_st_t          st;

   arb_pick #(.NPR_N(NPR_N), .NLVL(NLVL), .NDEV(NDEV), .PRI_W(PRI_W),
              .LVL_BASE(LVL_BASE)) pick_i (
      .npr_req(npr_req), .irq_req(irq_req), .cpu_pri(cpu_pri),
      .npr_any(npr_any), .npr_sel(npr_sel), .irq_ok(irq_ok), .irq_sel(irq_sel)
   );

   arb_fsm #(.NPR_N(NPR_N), .NIRQ(NIRQ), .PRI_W(PRI_W)) fsm_i (
      .clk(clk), .rst_n(rst_n), .bbsy_in(bbsy_in), .vec_valid(vec_valid),
      .npr_any(npr_any), .npr_sel(npr_sel), .irq_ok(irq_ok), .irq_sel(irq_sel),
      .seq_busy(seq_active), .npr_req(npr_req), .cpu_pri(cpu_pri),
      .npr_gnt(npr_gnt), .irq_gnt(irq_gnt), .seq_start(seq_start), .st(st)
   );

   assign bus_idle = !bbsy_in && (st == A_FREE) && !npr_any;

   entry_seq #(.AW(AW)) seq_i (
      .clk(clk), .rst_n(rst_n), .start(seq_start), .vec_in(vec_in),
      .sp_in(sp_in), .bus_idle(bus_idle), .bbsy_in(bbsy_in),
      .active(seq_active), .step_valid(step_valid), .step_kind(step_kind),
      .step_addr(step_addr)
   );

   assign cpu_stall = (st != A_FREE) || seq_active;

   // R8: no interrupt grant appears while entry steps were pending
   assert_irq_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(|irq_gnt) |-> !$past(seq_active));
   // R10: a visible grant always comes with the processor stalled
   assert_stall_gnt_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (|{npr_gnt, irq_gnt}) |-> cpu_stall);
endmodule

// File: tb/prio_bus_arb_tb_top.sv
module prio_bus_arb_tb_top;
   localparam int VW = 23;
   localparam int NV = 10;
   // {npr[1:0], irq[7:0], pri[2:0], exp_npr[1:0], exp_irq[7:0]}
   localparam logic [VW-1:0] TBL [NV] = '{
      {2'b01, 8'h00, 3'd7, 2'b01, 8'h00},
      {2'b10, 8'hFF, 3'd0, 2'b10, 8'h00},
      {2'b11, 8'h00, 3'd0, 2'b01, 8'h00},
      {2'b00, 8'h08, 3'd4, 2'b00, 8'h08},
      {2'b00, 8'h08, 3'd5, 2'b00, 8'h00},
      {2'b00, 8'h42, 3'd3, 2'b00, 8'h40},
      {2'b00, 8'h30, 3'd0, 2'b00, 8'h10},
      {2'b00, 8'h80, 3'd7, 2'b00, 8'h00},
      {2'b00, 8'h05, 3'd4, 2'b00, 8'h04},
      {2'b00, 8'h03, 3'd3, 2'b00, 8'h01}
   };

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [1:0]  npr_req = '0;
   logic [1:0]  npr_gnt;
   logic [7:0]  irq_req = '0;
   logic [7:0]  irq_gnt;
   logic [2:0]  cpu_pri = '0;
   logic        bbsy_in = 1'b0;
   logic        vec_valid = 1'b0;
   logic [15:0] vec_in = '0;
   logic [15:0] sp_in = '0;
   logic        cpu_stall, step_valid;
   logic [1:0]  step_kind;
   logic [15:0] step_addr;

   int total = 0;
   int bad = 0;
   bit done = 1'b0;

   always #5 clk = ~clk;

   prio_bus_arb dut_i (
      .clk(clk), .rst_n(rst_n), .npr_req(npr_req), .npr_gnt(npr_gnt),
      .irq_req(irq_req), .irq_gnt(irq_gnt), .cpu_pri(cpu_pri),
      .bbsy_in(bbsy_in), .vec_valid(vec_valid), .vec_in(vec_in),
      .sp_in(sp_in), .cpu_stall(cpu_stall), .step_valid(step_valid),
      .step_kind(step_kind), .step_addr(step_addr)
   );

   task automatic tick();
      @(posedge clk);
      #1;
   endtask

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s act=%h exp=%h", req, act, exp);
      end
   endtask

   task automatic step_chk(input string req, input logic [1:0] k, input logic [15:0] a);
      chk(req, {31'd0, step_valid}, 32'd1);
      chk(req, {30'd0, step_kind}, {30'd0, k});
      chk(req, {16'd0, step_addr}, {16'd0, a});
   endtask

   task automatic release_bus();
      npr_req = '0; irq_req = '0;
      bbsy_in = 1'b1; tick();
      vec_valid = 1'b1; vec_in = 16'h0200; tick();
      vec_valid = 1'b0; bbsy_in = 1'b0;
      repeat (8) tick();
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         bad++; total++;
         $display("FAIL watchdog expired");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      repeat (3) tick();
      // R1: reset state
      chk("R1 gnt", {22'd0, npr_gnt, irq_gnt}, 32'd0);
      chk("R1 stall", {31'd0, cpu_stall}, 32'd0);
      chk("R1 step", {31'd0, step_valid}, 32'd0);
      rst_n = 1'b1; tick();

      // R2 R3 R4: priority table
      for (int i = 0; i < NV; i++) begin
         logic [VW-1:0] v;
         v = TBL[i];
         npr_req = v[22:21]; irq_req = v[20:13]; cpu_pri = v[12:10];
         tick();
         chk("R2/R3/R4 npr_gnt", {30'd0, npr_gnt}, {30'd0, v[9:8]});
         chk("R2/R3/R4 irq_gnt", {24'd0, irq_gnt}, {24'd0, v[7:0]});
         release_bus();
         chk("R10 stall idle", {31'd0, cpu_stall}, 32'd0);
      end

      // R5 R6: grant hold, busy blocking, release
      cpu_pri = 3'd0;
      npr_req = 2'b10; tick();
      chk("R5 gnt held", {30'd0, npr_gnt}, 32'd2);
      npr_req = 2'b01; tick();
      chk("R5 one grant", {30'd0, npr_gnt}, 32'd2);
      chk("R10 stall gnt", {31'd0, cpu_stall}, 32'd1);
      bbsy_in = 1'b1; tick();
      chk("R5 gnt dropped", {30'd0, npr_gnt}, 32'd0);
      tick();
      chk("R5 no gnt busy", {30'd0, npr_gnt}, 32'd0);
      npr_req = '0; bbsy_in = 1'b0; tick();
      chk("R6 stall release", {31'd0, cpu_stall}, 32'd0);
      tick();

      // R7 R8 R9 R10: entry sequence with a direct transfer in the middle
      sp_in = 16'h1000;
      irq_req = 8'h40; tick();
      chk("R7 irq gnt", {24'd0, irq_gnt}, 32'h40);
      irq_req = '0; bbsy_in = 1'b1; tick();
      chk("R5 irq gnt dropped", {24'd0, irq_gnt}, 32'd0);
      vec_valid = 1'b1; vec_in = 16'h0040; tick();
      vec_valid = 1'b0; bbsy_in = 1'b0; sp_in = 16'h7777; tick();
      chk("R10 stall seq", {31'd0, cpu_stall}, 32'd1);
      irq_req = 8'h80; npr_req = 2'b01; tick();
      chk("R8 npr during seq", {30'd0, npr_gnt}, 32'd1);
      chk("R8 irq held off", {24'd0, irq_gnt}, 32'd0);
      chk("R9 no step npr", {31'd0, step_valid}, 32'd0);
      npr_req = '0; bbsy_in = 1'b1; tick();
      tick();
      chk("R9 no step busy", {31'd0, step_valid}, 32'd0);
      bbsy_in = 1'b0; tick();
      chk("R9 no step own", {31'd0, step_valid}, 32'd0);
      tick();
      step_chk("R7 push ps", 2'd0, 16'h0FFE);
      chk("R8 irq still held", {24'd0, irq_gnt}, 32'd0);
      tick(); step_chk("R7 push pc", 2'd1, 16'h0FFC);
      tick(); step_chk("R7 load pc", 2'd2, 16'h0040);
      chk("R10 stall before last", {31'd0, cpu_stall}, 32'd1);
      tick(); step_chk("R7 load ps", 2'd3, 16'h0042);
      chk("R10 stall after last", {31'd0, cpu_stall}, 32'd0);
      tick();
      chk("R8 irq after seq", {24'd0, irq_gnt}, 32'h80);
      chk("R7 no extra step", {31'd0, step_valid}, 32'd0);
      release_bus();

      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule